// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block gathers a bank of external interrupt pins, organised as groups of eight lines, and turns pin activity into interrupt requests. Each line carries a trigger selection (low level, high level, falling edge, rising edge or either edge), an enable-style mask bit and a sticky pending flag. Software reaches the configuration and status through a plain 32-bit register port with address, write strobe, write data and a combinational read-data return.

Every pin is brought into the clock domain by a two-stage synchronizer. Edges are found by comparing the synchronized sample with the one taken a cycle earlier. A detected event latches the line's pending flag whether the line is masked or not. The mask acts only on the outputs. The low sixteen lines each drive a dedicated request output. All the remaining lines share one combined request, which is raised while any of them is both pending and unmasked.

Top module: `xint_trigger_ctrl`

## Requirements
- R1: While reset is held, every trigger field and filter register reads 0, every mask register reads 0x000000FF, every pending register reads 0, and both interrupt outputs are low.
- R2: Line n lives in group g = n / 8 at bit b = n mod 8. Its 4-bit trigger field occupies bits [4b+3:4b] of the trigger register at byte address 0xE00 + 4g. Its mask bit is bit b at 0xF00 + 4g, and its pending bit is bit b at 0xF40 + 4g.
- R3: Trigger code 0 (low level) sets pending on every cycle the synchronized pin is 0, and code 1 (high level) does the same on every cycle it is 1. Clearing while the level persists leaves the bit set.
- R4: Code 2 sets pending only on a 1-to-0 transition and code 3 only on a 0-to-1 transition. A steady pin or a transition of the other direction leaves the bit clear.
- R5: Code 4 sets pending on transitions in both directions.
- R6: Codes 5, 6 and 7 never set pending. Bit 3 of each trigger field is ignored on write and reads back as 0.
- R7: Writing to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. Without such a write or a new event, a pending bit holds its value.
- R8: An event sets its pending bit even while the line is masked. A mask bit of 1 keeps that line's request off the outputs.
- R9: `irq_direct[n]` for n < 16 is high exactly while line n is pending and its mask bit is 0.
- R10: `irq_shared` is high exactly while at least one of lines 16 to 31 is pending with its mask bit 0.
- R11: Each group's 32-bit filter register at 0xE80 + 4g holds any value written and reads it back. Its contents do not change event detection.
- R12: Bits 31:8 of mask and pending registers read 0. Addresses outside the four register sets read 0, and writes to them change nothing.
- R13: A pin transition driven between clock edges becomes visible in the pending register after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous external interrupt pins |
| irq_direct | output | 16 | Per-line requests for lines 0 to 15 |
| irq_shared | output | 1 | Combined request for lines 16 to 31 |

## Verification
The bench builds the block with its default parameters: four groups and sixteen dedicated outputs. With these values every register set has one address per group, and the boundary between dedicated and shared outputs falls between lines 15 and 16. Both lines on either side of that boundary are exercised, as are lines in the last group, whose fields sit at the upper bit positions. Lines that are not under test are parked on a reserved trigger code, so each scenario observes only the line it drives.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int GRP_LINES = 8;
  localparam int FIELD_W   = 4;
  localparam int CODE_W    = 3;
  localparam int REG_STEP  = 4;
  localparam int CTRL_BASE = 'hE00;
  localparam int FILT_BASE = 'hE80;
  localparam int MASK_BASE = 'hF00;
  localparam int PEND_BASE = 'hF40;

  typedef enum logic [CODE_W-1:0] {
    TRIG_LEVEL_LO  = 3'd0,
    TRIG_LEVEL_HI  = 3'd1,
    TRIG_EDGE_FALL = 3'd2,
    TRIG_EDGE_RISE = 3'd3,
    TRIG_EDGE_ANY  = 3'd4
  } trig_e;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/xint_detect.sv
module xint_detect
  import xint_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              cur_i,
  input  logic              prev_i,
  output logic              evt_o
);
  always_comb begin
    case (code_i)
      TRIG_LEVEL_LO:  evt_o = ~cur_i;
      TRIG_LEVEL_HI:  evt_o = cur_i;
      TRIG_EDGE_FALL: evt_o = prev_i & ~cur_i;
      TRIG_EDGE_RISE: evt_o = cur_i & ~prev_i;
      TRIG_EDGE_ANY:  evt_o = cur_i ^ prev_i;
      default:        evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xint_regfile.sv
module xint_regfile
  import xint_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  localparam int NL        = NUM_GROUPS * GRP_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NL-1:0]        evt_i,
  output logic [NL*CODE_W-1:0] trig_o,
  output logic [NL-1:0]        mask_o,
  output logic [NL-1:0]        pend_o
);
  logic [NUM_GROUPS-1:0] sel_ctrl, sel_filt, sel_mask, sel_pend;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign sel_ctrl[g] = (bus_addr == ADDR_W'(CTRL_BASE + REG_STEP * g));
    assign sel_filt[g] = (bus_addr == ADDR_W'(FILT_BASE + REG_STEP * g));
    assign sel_mask[g] = (bus_addr == ADDR_W'(MASK_BASE + REG_STEP * g));
    assign sel_pend[g] = (bus_addr == ADDR_W'(PEND_BASE + REG_STEP * g));
  end

  logic [NL*CODE_W-1:0]     trig_q, trig_d;
  logic [NUM_GROUPS*DATA_W-1:0] filt_q, filt_d;
  logic [NL-1:0]            mask_q, mask_d, pend_q, pend_d;
  logic                     cfg_en;

  assign cfg_en = bus_we & (|{sel_ctrl, sel_filt, sel_mask});

  always_comb begin
    trig_d = trig_q;
    filt_d = filt_q;
    mask_d = mask_q;
    pend_d = pend_q;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (bus_we && sel_ctrl[g]) begin
        for (int l = 0; l < GRP_LINES; l++)
          trig_d[(g*GRP_LINES+l)*CODE_W +: CODE_W] = bus_wdata[l*FIELD_W +: CODE_W];
      end
      if (bus_we && sel_filt[g]) filt_d[g*DATA_W +: DATA_W] = bus_wdata;
      if (bus_we && sel_mask[g]) mask_d[g*GRP_LINES +: GRP_LINES] = bus_wdata[GRP_LINES-1:0];
      if (bus_we && sel_pend[g])
        pend_d[g*GRP_LINES +: GRP_LINES] = pend_q[g*GRP_LINES +: GRP_LINES] & ~bus_wdata[GRP_LINES-1:0];
    end
    pend_d = pend_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      filt_q <= '0;
      mask_q <= '1;
    end else if (cfg_en) begin
      trig_q <= trig_d;
      filt_q <= filt_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_ctrl[g]) begin
        for (int l = 0; l < GRP_LINES; l++)
          bus_rdata[l*FIELD_W +: CODE_W] = trig_q[(g*GRP_LINES+l)*CODE_W +: CODE_W];
      end
      if (sel_filt[g]) bus_rdata = filt_q[g*DATA_W +: DATA_W];
      if (sel_mask[g]) bus_rdata[GRP_LINES-1:0] = mask_q[g*GRP_LINES +: GRP_LINES];
      if (sel_pend[g]) bus_rdata[GRP_LINES-1:0] = pend_q[g*GRP_LINES +: GRP_LINES];
    end
  end

  assign trig_o = trig_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/xint_trigger_ctrl.sv
module xint_trigger_ctrl
  import xint_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int DIRECT_LINES = 16,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  localparam int NL          = NUM_GROUPS * GRP_LINES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NL-1:0]           pin_in,
  output logic [DIRECT_LINES-1:0] irq_direct,
  output logic                    irq_shared
);
  logic [NL-1:0]        pin_cur, pin_prev, line_evt, line_mask, line_pend;
  logic [NL*CODE_W-1:0] trig_codes;
  logic [NL-1:0]        line_req;

  xint_sync #(.WIDTH(NL)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_in),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  for (genvar n = 0; n < NL; n++) begin : g_line
    xint_detect u_det (
      .code_i (trig_codes[n*CODE_W +: CODE_W]),
      .cur_i  (pin_cur[n]),
      .prev_i (pin_prev[n]),
      .evt_o  (line_evt[n])
    );
  end

  xint_regfile #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (line_evt),
    .trig_o    (trig_codes),
    .mask_o    (line_mask),
    .pend_o    (line_pend)
  );

  assign line_req   = line_pend & ~line_mask;
  assign irq_direct = line_req[DIRECT_LINES-1:0];
  assign irq_shared = |line_req[NL-1:DIRECT_LINES];
endmodule

// File: rtl/xint_trigger_ctrl_chk.sv
module xint_trigger_ctrl_chk
  import xint_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int DIRECT_LINES = 16,
  parameter int ADDR_W       = 12,
  localparam int NL          = NUM_GROUPS * GRP_LINES
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_we,
  input logic [GRP_LINES-1:0]    wr_low,
  input logic [DIRECT_LINES-1:0] irq_direct,
  input logic                    irq_shared,
  input logic [NL-1:0]           evt,
  input logic [NL*CODE_W-1:0]    trig_flat,
  input logic [DIRECT_LINES-1:0] mask_lo,
  input logic [NL-1:0]           pend_q
);
  logic pend_wr;
  always_comb begin
    pend_wr = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (bus_we && bus_addr == ADDR_W'(PEND_BASE + REG_STEP * g)) pend_wr = 1'b1;
  end

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend_q & $past(evt)) == $past(evt))); // R8

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && evt == '0) |=> $stable(pend_q)); // R7

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_w1c
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(PEND_BASE + REG_STEP * g)) |=>
      ((pend_q[g*GRP_LINES +: GRP_LINES] & $past(wr_low & ~evt[g*GRP_LINES +: GRP_LINES])) == '0)); // R7
  end

  for (genvar n = 0; n < NL; n++) begin : g_rsvd
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_flat[n*CODE_W +: CODE_W] > 3'd4) |-> !evt[n]); // R6
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_direct & mask_lo) == '0); // R8

  AST_SHARED_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> (|pend_q[NL-1:DIRECT_LINES])); // R10
endmodule

bind xint_trigger_ctrl xint_trigger_ctrl_chk #(
  .NUM_GROUPS   (NUM_GROUPS),
  .DIRECT_LINES (DIRECT_LINES),
  .ADDR_W       (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .wr_low     (bus_wdata[7:0]),
  .irq_direct (irq_direct),
  .irq_shared (irq_shared),
  .evt        (line_evt),
  .trig_flat  (trig_codes),
  .mask_lo    (line_mask[DIRECT_LINES-1:0]),
  .pend_q     (line_pend)
);

// File: tb/xint_trigger_ctrl_tb.sv
module xint_trigger_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [15:0] irq_direct;
  logic        irq_shared;
  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  xint_trigger_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  function automatic logic [11:0] a_ctrl(int g); return 12'(32'hE00 + 4*g); endfunction
  function automatic logic [11:0] a_filt(int g); return 12'(32'hE80 + 4*g); endfunction
  function automatic logic [11:0] a_mask(int g); return 12'(32'hF00 + 4*g); endfunction
  function automatic logic [11:0] a_pend(int g); return 12'(32'hF40 + 4*g); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_code(input int line, input logic [3:0] code);
    logic [31:0] v;
    rd(a_ctrl(line / 8), v);
    v = (v & ~(32'hF << (4 * (line % 8)))) | (32'(code) << (4 * (line % 8)));
    wr(a_ctrl(line / 8), v);
  endtask

  task automatic quiet();
    logic [31:0] v;
    for (int g = 0; g < 4; g++) wr(a_ctrl(g), 32'h5555_5555);
    for (int g = 0; g < 4; g++) wr(a_mask(g), 32'hFF);
    for (int g = 0; g < 4; g++) wr(a_pend(g), 32'hFF);
    tick(2);
    for (int g = 0; g < 4; g++) begin
      rd(a_pend(g), v); chk("R6 reserved idle", v, 0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    tick(2);
    for (int g = 0; g < 4; g++) begin
      rd(a_ctrl(g), v); chk("R1 ctrl", v, 0);
      rd(a_filt(g), v); chk("R1 filt", v, 0);
      rd(a_mask(g), v); chk("R1 mask", v, 32'hFF);
      rd(a_pend(g), v); chk("R1 pend", v, 0);
    end
    chk("R1 irq_direct", 32'(irq_direct), 0);
    chk("R1 irq_shared", 32'(irq_shared), 0);
    rst_n = 1'b1;
    tick(4);
    rd(a_pend(0), v); chk("R8 masked low-level pends", v, 32'hFF);
    chk("R8 masked outputs off", 32'(irq_direct), 0);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    set_code(3, 4'd1);
    pins[3] = 1'b1; tick(4);
    rd(a_pend(0), v); chk("R3 high level", v, 32'h08);
    wr(a_pend(0), 32'h08); rd(a_pend(0), v); chk("R3 clear while held", v, 32'h08);
    pins[3] = 1'b0; tick(4);
    wr(a_pend(0), 32'h08); rd(a_pend(0), v); chk("R7 w1c", v, 0);
    set_code(3, 4'd5);
    pins[9] = 1'b1; tick(4);
    set_code(9, 4'd0); tick(2);
    rd(a_pend(1), v); chk("R3 low level high pin", v, 0);
    pins[9] = 1'b0; tick(4);
    rd(a_pend(1), v); chk("R3 low level", v, 32'h02);
    pins[9] = 1'b1; tick(4);
    wr(a_pend(1), 32'h00); rd(a_pend(1), v); chk("R7 zero write keeps", v, 32'h02);
    wr(a_pend(1), 32'h02); rd(a_pend(1), v); chk("R7 cleared", v, 0);
    set_code(9, 4'd5); pins[9] = 1'b0; tick(4);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    set_code(20, 4'd3);
    pins[20] = 1'b1; tick(2);
    rd(a_pend(2), v); chk("R13 not after 2 edges", v, 0);
    tick(1);
    rd(a_pend(2), v); chk("R13 after 3 edges", v, 32'h10);
    wr(a_pend(2), 32'h10); tick(3);
    rd(a_pend(2), v); chk("R4 rising single shot", v, 0);
    pins[20] = 1'b0; tick(4);
    rd(a_pend(2), v); chk("R4 rising ignores fall", v, 0);
    set_code(20, 4'd5);
    set_code(5, 4'd2);
    pins[5] = 1'b1; tick(4);
    rd(a_pend(0), v); chk("R4 falling ignores rise", v, 0);
    pins[5] = 1'b0; tick(4);
    rd(a_pend(0), v); chk("R4 falling", v, 32'h20);
    wr(a_pend(0), 32'h20); set_code(5, 4'd5);
    set_code(30, 4'd4);
    pins[30] = 1'b1; tick(4);
    rd(a_pend(3), v); chk("R5 both rise", v, 32'h40);
    wr(a_pend(3), 32'h40);
    pins[30] = 1'b0; tick(4);
    rd(a_pend(3), v); chk("R5 both fall", v, 32'h40);
    wr(a_pend(3), 32'h40); set_code(30, 4'd5);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    for (int c = 5; c < 8; c++) begin
      set_code(12, 4'(c));
      pins[12] = ~pins[12]; tick(4);
      pins[12] = ~pins[12]; tick(4);
      rd(a_pend(1), v); chk("R6 reserved code", v, 0);
    end
    set_code(2, 4'hB);
    rd(a_ctrl(0), v); chk("R6 bit3 dropped", (v >> 8) & 32'hF, 32'h3);
    pins[2] = 1'b1; tick(4);
    rd(a_pend(0), v); chk("R6 code 0xB acts as rising", v, 32'h04);
    pins[2] = 1'b0; wr(a_pend(0), 32'h04); set_code(2, 4'd5);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    set_code(7, 4'd1); pins[7] = 1'b1; tick(4);
    rd(a_pend(0), v); chk("R8 masked still pends", v, 32'h80);
    chk("R8 masked no output", 32'(irq_direct), 0);
    wr(a_mask(0), 32'h7F);
    chk("R9 line 7 out", 32'(irq_direct), 32'h0080);
    set_code(15, 4'd3); pins[15] = 1'b1; tick(4);
    chk("R9 line 15 masked", 32'(irq_direct), 32'h0080);
    wr(a_mask(1), 32'h7F);
    chk("R9 line 15 out", 32'(irq_direct), 32'h8080);
    chk("R10 shared idle", 32'(irq_shared), 0);
    wr(a_mask(0), 32'hFF); wr(a_mask(1), 32'hFF);
    set_code(7, 4'd5); set_code(15, 4'd5);
    wr(a_pend(0), 32'hFF); wr(a_pend(1), 32'hFF);
    set_code(16, 4'd3); pins[16] = 1'b1; tick(4);
    chk("R10 masked shared", 32'(irq_shared), 0);
    wr(a_mask(2), 32'hFE);
    chk("R10 line 16 shared", 32'(irq_shared), 1);
    chk("R10 no direct", 32'(irq_direct), 0);
    wr(a_pend(2), 32'h01);
    chk("R10 shared drops", 32'(irq_shared), 0);
    set_code(31, 4'd3); pins[31] = 1'b1; tick(4);
    wr(a_mask(3), 32'h7F);
    chk("R10 line 31 shared", 32'(irq_shared), 1);
    wr(a_mask(2), 32'hFF); wr(a_mask(3), 32'hFF);
    set_code(16, 4'd5); set_code(31, 4'd5);
    wr(a_pend(3), 32'hFF);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(a_filt(1), 32'hDEAD_BEEF);
    rd(a_filt(1), v); chk("R11 filter readback", v, 32'hDEAD_BEEF);
    set_code(10, 4'd3); pins[10] = 1'b1; tick(4);
    rd(a_pend(1), v); chk("R11 filter no effect", v, 32'h04);
    wr(a_pend(1), 32'h04); set_code(10, 4'd5);
    wr(a_ctrl(3), 32'h5555_5355);
    rd(a_ctrl(3), v); chk("R2 field position", v, 32'h5555_5355);
    pins[26] = 1'b1; tick(4);
    rd(a_pend(3), v); chk("R2 group 3 bit 2", v, 32'h04);
    rd(a_pend(0), v); chk("R2 other group quiet", v, 0);
    wr(a_pend(3), 32'h04);
    wr(a_mask(0), 32'hFFFF_FFFF);
    rd(a_mask(0), v); chk("R12 mask upper zero", v, 32'hFF);
    wr(a_pend(0), 32'hFFFF_FF00);
    rd(a_pend(0), v); chk("R12 pend upper zero", v, 0);
    wr(12'hE10, 32'h1234_5678);
    rd(12'hE10, v); chk("R12 unmapped reads 0", v, 0);
    rd(a_ctrl(0), v); chk("R12 unmapped write ignored", v, 32'h5555_5555);
    rd(12'h000, v); chk("R12 low address 0", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    quiet();
    t_levels();
    t_edges();
    t_reserved();
    t_outputs();
    t_regs();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule